// File: doc/BRIEF.md
# Programmed-I/O Frame Buffer Network Controller

This block is a minimal network controller that a host drives entirely through a small window of 32-bit registers. To send, the host programs a frame length and then writes the frame one byte at a time into a transmit buffer. When the last byte of the programmed length arrives, the stored frame is sent out on a byte-stream port that uses valid, ready and last. To receive, a frame arrives on a byte-stream input and is stored in a receive buffer. The host then reads it out one byte at a time through a data register, and a count register drops by one on every read.

A small interrupt control register holds three flags: transmit done, receive done and a test bit. Any flag that is set drives one level-sensitive interrupt line. A busy flag blocks reception until the host has cleared the flags. The test bit also works as a soft reset: writing it restores the reset state of the block and then sets the flag, and reading the register clears it again. The buffer capacity `MAX_FRAME` is a parameter with a default of 1514 bytes.

Top module: `pio_frame_nic`

## Requirements
- R1: After reset the busy flag reads 1, all counts and interrupt flags read 0, `irq` is low, `txValid` is low and `rxReady` is low.
- R2: The register offsets are as follows.
  - 0x00 and 0x04 return the identification words 0x5046_4E49 and 0x4330_0001.
  - 0x08 returns busy in bit 0.
  - 0x0c returns the receive count and 0x10 returns the transmit count.
  - 0x14 is interrupt control.
  - 0x1c is receive data and 0x20 is transmit data.
  - 0x18, 0x20 and every unmapped offset read as 0.
  - Writes to 0x00, 0x04, 0x08, 0x0c, 0x18 and 0x1c change nothing.
- R3: Interrupt control has transmit-done in bit 0, receive-done in bit 1 and the test bit in bit 31, and `irq` is high while any of them is set. A write acts on the first match only:
  - bit 0 set clears transmit-done;
  - otherwise bit 1 set clears receive-done;
  - otherwise bit 31 set performs a soft reset and then sets the test bit.

  After any write to this register, busy equals the OR of the remaining flags.
- R4: A read of interrupt control returns the current value and clears the test bit.
- R5: Writing the transmit count loads the value, or 0 if the value exceeds `MAX_FRAME`, and resets the transmit write position to 0.
- R6: Each transmit data write stores byte [7:0] at the write position and advances it. When the position reaches the count, the frame is sent with `txLast` on its final byte. In the same step the count and position return to 0, transmit-done is set and busy becomes 1. Transmit data writes are ignored while the count is 0 or while `hostStall` is high during sending.
- R7: While `txValid` is high and `txReady` is low, `txData` and `txLast` hold their values.
- R8: An incoming frame is accepted only if busy is 0 and the receive count is below `MAX_FRAME` when its first byte is offered. Otherwise `rxReady` stays low. Once a frame is accepted, `rxReady` stays high until its last byte, and busy is set on the first byte.
- R9: At the last byte of an accepted frame, the receive count is loaded with the frame length, the read position is cleared and receive-done is set. Bytes beyond `MAX_FRAME` are dropped, so the count is capped at `MAX_FRAME`.
- R10: A read of receive data with a nonzero count returns the next byte and decrements the count. With a count of 0 it returns 0.
- R11: Events from the streams override a same-cycle register write. A frame's first or last byte leaves busy at 1 even when an interrupt control write in the same cycle would clear it. A frame end and a transmit launch in the same cycle set both done flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 6 | Register offset (already masked to 6 bits) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (triggers read side effects) |
| regWData | input | 32 | Write data |
| regRData | output | 32 | Read data for `regAddr`, combinational |
| hostStall | output | 1 | High while a frame is being sent; host holds transmit data writes |
| irq | output | 1 | Level interrupt, high while any flag is set |
| txData | output | 8 | Outgoing frame byte |
| txValid | output | 1 | Outgoing byte valid |
| txReady | input | 1 | Sink accepts the outgoing byte |
| txLast | output | 1 | Final byte of the outgoing frame |
| rxData | input | 8 | Incoming frame byte |
| rxValid | input | 1 | Incoming byte valid |
| rxLast | input | 1 | Final byte of the incoming frame |
| rxReady | output | 1 | Block accepts the incoming byte |

## Verification
Two functions share the busy flag and the interrupt flags and can act in the same cycle.

- **First collision.** The host writes zero to interrupt control in the same cycle as the first byte of an incoming frame is accepted. The register write would compute busy as 0, but the stream start must win, so busy is read back as 1 in the following cycle.
- **Second collision.** The final transmit data write, which launches a frame, coincides with the last byte of that incoming frame.

The outcome is judged by reading interrupt control, which must show both done flags, and by checking that the sent byte and the two received bytes are intact.

// File: rtl/nic_pkg.sv
package nic_pkg;

  localparam logic [5:0] OFF_ID0    = 6'h00;
  localparam logic [5:0] OFF_ID1    = 6'h04;
  localparam logic [5:0] OFF_BUSY   = 6'h08;
  localparam logic [5:0] OFF_RXCNT  = 6'h0c;
  localparam logic [5:0] OFF_TXCNT  = 6'h10;
  localparam logic [5:0] OFF_IRQCTL = 6'h14;
  localparam logic [5:0] OFF_INFO   = 6'h18;
  localparam logic [5:0] OFF_RXDATA = 6'h1c;
  localparam logic [5:0] OFF_TXDATA = 6'h20;

  // Strobes from control to datapath
  typedef struct packed {
    logic txStore;   // write host byte into transmit buffer
    logic txLaunch;  // start emitting the stored frame
    logic rxPop;     // host consumed one receive byte
    logic softRst;   // test-bit soft reset
  } nicStrobe_t;

endpackage

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int          MAX_FRAME = 1514,
  parameter int          PTR_W     = 11,
  parameter logic [31:0] ID_WORD0  = 32'h5046_4E49,
  parameter logic [31:0] ID_WORD1  = 32'h4330_0001
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [5:0]       offset,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [31:0]      regWData,
  output logic [31:0]      regRData,
  input  logic             drainBusy,
  input  logic             rxStart,
  input  logic             rxEnd,
  input  logic [PTR_W-1:0] rxLen,
  input  logic [7:0]       rxByte,
  output nicStrobe_t       strb,
  output logic [PTR_W-1:0] txWPtr,
  output logic [PTR_W-1:0] txCount,
  output logic [PTR_W-1:0] rdPtr,
  output logic [PTR_W-1:0] rxCount,
  output logic             busy,
  output logic             canAccept,
  output logic             irq
);

  localparam logic [PTR_W-1:0] MAX_CNT = PTR_W'(MAX_FRAME);

  logic txDone, rxDone, testFlag;
  logic nTxDone, nRxDone, nTest, nBusy;
  logic [PTR_W-1:0] nTxCount, nTxWPtr, nRxCount, nRdPtr;

  always_comb begin
    strb     = '0;
    nTxDone  = txDone;
    nRxDone  = rxDone;
    nTest    = testFlag;
    nBusy    = busy;
    nTxCount = txCount;
    nTxWPtr  = txWPtr;
    nRxCount = rxCount;
    nRdPtr   = rdPtr;

    if (regRd) begin
      if (offset == OFF_IRQCTL) nTest = 1'b0;
      if (offset == OFF_RXDATA && rxCount != '0) begin
        strb.rxPop = 1'b1;
        nRxCount   = rxCount - 1'b1;
        nRdPtr     = rdPtr + 1'b1;
      end
    end

    if (regWr) begin
      case (offset)
        OFF_TXCNT: begin
          nTxCount = (regWData > 32'(MAX_FRAME)) ? '0 : regWData[PTR_W-1:0];
          nTxWPtr  = '0;
        end
        OFF_IRQCTL: begin
          if (regWData[0])       nTxDone = 1'b0;
          else if (regWData[1])  nRxDone = 1'b0;
          else if (regWData[31]) strb.softRst = 1'b1;
          if (strb.softRst) begin
            nTxCount = '0;
            nTxWPtr  = '0;
            nRxCount = '0;
            nRdPtr   = '0;
            nTxDone  = 1'b0;
            nRxDone  = 1'b0;
            nTest    = 1'b1;
          end
          nBusy = nTxDone | nRxDone | nTest;
        end
        OFF_TXDATA: begin
          if (!drainBusy && txCount != '0) begin
            strb.txStore = 1'b1;
            if (txWPtr + 1'b1 == txCount) begin
              strb.txLaunch = 1'b1;
              nTxCount = '0;
              nTxWPtr  = '0;
              nTxDone  = 1'b1;
              nBusy    = 1'b1;
            end else begin
              nTxWPtr = txWPtr + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end

    // stream events take precedence over the register write
    if (!strb.softRst) begin
      if (rxStart) nBusy = 1'b1;
      if (rxEnd) begin
        nRxCount = rxLen;
        nRdPtr   = '0;
        nRxDone  = 1'b1;
        nBusy    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b1;
      txDone   <= 1'b0;
      rxDone   <= 1'b0;
      testFlag <= 1'b0;
      txCount  <= '0;
      txWPtr   <= '0;
      rxCount  <= '0;
      rdPtr    <= '0;
    end else begin
      busy     <= nBusy;
      txDone   <= nTxDone;
      rxDone   <= nRxDone;
      testFlag <= nTest;
      txCount  <= nTxCount;
      txWPtr   <= nTxWPtr;
      rxCount  <= nRxCount;
      rdPtr    <= nRdPtr;
    end
  end

  assign canAccept = !busy && (rxCount < MAX_CNT);
  assign irq       = txDone | rxDone | testFlag;

  always_comb begin
    case (offset)
      OFF_ID0:    regRData = ID_WORD0;
      OFF_ID1:    regRData = ID_WORD1;
      OFF_BUSY:   regRData = {31'b0, busy};
      OFF_RXCNT:  regRData = 32'(rxCount);
      OFF_TXCNT:  regRData = 32'(txCount);
      OFF_IRQCTL: regRData = {testFlag, 29'b0, rxDone, txDone};
      OFF_RXDATA: regRData = (rxCount != '0) ? {24'b0, rxByte} : 32'b0;
      default:    regRData = 32'b0;
    endcase
  end

endmodule

// File: rtl/nic_datapath.sv
module nic_datapath
  import nic_pkg::*;
#(
  parameter int MAX_FRAME = 1514,
  parameter int PTR_W     = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  nicStrobe_t       strb,
  input  logic [PTR_W-1:0] txWPtr,
  input  logic [7:0]       txByte,
  input  logic [PTR_W-1:0] txLen,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             canAccept,
  output logic [7:0]       txData,
  output logic             txValid,
  input  logic             txReady,
  output logic             txLast,
  input  logic [7:0]       rxData,
  input  logic             rxValid,
  input  logic             rxLast,
  output logic             rxReady,
  output logic [7:0]       rxByte,
  output logic             drainBusy,
  output logic             rxStart,
  output logic             rxEnd,
  output logic [PTR_W-1:0] rxLen
);

  localparam logic [PTR_W-1:0] MAX_CNT = PTR_W'(MAX_FRAME);

  logic [7:0] txMem [MAX_FRAME];
  logic [7:0] rxMem [MAX_FRAME];

  // ---------------- transmit side ----------------
  logic             draining;
  logic [PTR_W-1:0] drainIdx, drainLen;
  logic             atLastByte;

  always_ff @(posedge clk) begin
    if (strb.txStore) txMem[txWPtr] <= txByte;
  end

  assign atLastByte = (drainIdx == drainLen - 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      draining <= 1'b0;
      drainIdx <= '0;
      drainLen <= '0;
    end else if (strb.softRst) begin
      draining <= 1'b0;
    end else if (strb.txLaunch) begin
      draining <= 1'b1;
      drainIdx <= '0;
      drainLen <= txLen;
    end else if (draining && txReady) begin
      if (atLastByte) draining <= 1'b0;
      else            drainIdx <= drainIdx + 1'b1;
    end
  end

  assign txValid   = draining;
  assign txData    = txMem[drainIdx];
  assign txLast    = draining && atLastByte;
  assign drainBusy = draining;

  // ---------------- receive side ----------------
  logic             rxActive;
  logic [PTR_W-1:0] rxWPtr, wIdx;
  logic             rxBeat, doStore;

  assign rxReady = rxActive | canAccept;
  assign rxBeat  = rxValid & rxReady;
  assign rxStart = rxBeat & ~rxActive;
  assign rxEnd   = rxBeat & rxLast;
  assign wIdx    = rxActive ? rxWPtr : '0;
  assign doStore = rxBeat && (wIdx < MAX_CNT);
  assign rxLen   = doStore ? wIdx + 1'b1 : wIdx;

  always_ff @(posedge clk) begin
    if (doStore) rxMem[wIdx] <= rxData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxActive <= 1'b0;
      rxWPtr   <= '0;
    end else if (strb.softRst) begin
      rxActive <= 1'b0;
    end else if (rxBeat) begin
      rxActive <= ~rxLast;
      rxWPtr   <= rxLen;
    end
  end

  assign rxByte = rxMem[rdPtr];

endmodule

// File: rtl/pio_frame_nic.sv
module pio_frame_nic
  import nic_pkg::*;
#(
  parameter int          MAX_FRAME = 1514,
  parameter logic [31:0] ID_WORD0  = 32'h5046_4E49,
  parameter logic [31:0] ID_WORD1  = 32'h4330_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [5:0]  regAddr,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [31:0] regWData,
  output logic [31:0] regRData,
  output logic        hostStall,
  output logic        irq,
  output logic [7:0]  txData,
  output logic        txValid,
  input  logic        txReady,
  output logic        txLast,
  input  logic [7:0]  rxData,
  input  logic        rxValid,
  input  logic        rxLast,
  output logic        rxReady
);

  localparam int PTR_W = $clog2(MAX_FRAME + 1);

  nicStrobe_t       strb;
  logic [PTR_W-1:0] txWPtr, txCount, rdPtr, rxCount, rxLen;
  logic             busy, canAccept, drainBusy, rxStart, rxEnd;
  logic [7:0]       rxByte;

  nic_ctrl #(
    .MAX_FRAME(MAX_FRAME), .PTR_W(PTR_W), .ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .offset(regAddr), .regWr(regWr), .regRd(regRd),
    .regWData(regWData), .regRData(regRData), .drainBusy(drainBusy),
    .rxStart(rxStart), .rxEnd(rxEnd), .rxLen(rxLen), .rxByte(rxByte),
    .strb(strb), .txWPtr(txWPtr), .txCount(txCount), .rdPtr(rdPtr),
    .rxCount(rxCount), .busy(busy), .canAccept(canAccept), .irq(irq)
  );

  nic_datapath #(.MAX_FRAME(MAX_FRAME), .PTR_W(PTR_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txWPtr(txWPtr), .txByte(regWData[7:0]),
    .txLen(txCount), .rdPtr(rdPtr), .canAccept(canAccept),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLast(txLast),
    .rxData(rxData), .rxValid(rxValid), .rxLast(rxLast), .rxReady(rxReady),
    .rxByte(rxByte), .drainBusy(drainBusy), .rxStart(rxStart), .rxEnd(rxEnd),
    .rxLen(rxLen)
  );

  assign hostStall = drainBusy;

endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
  parameter int MAX_FRAME = 1514,
  parameter int PTR_W     = 11
) (
  input logic             clk,
  input logic             rstN,
  input logic [5:0]       regAddr,
  input logic             regWr,
  input logic             regRd,
  input logic [31:0]      regWData,
  input logic             irq,
  input logic             hostStall,
  input logic [7:0]       txData,
  input logic             txValid,
  input logic             txReady,
  input logic             txLast,
  input logic             rxValid,
  input logic             rxReady,
  input logic             rxLast,
  input logic             busy,
  input logic [PTR_W-1:0] rxCount,
  input logic [PTR_W-1:0] txCount
);

  logic irqCtlWr, rxEndBeat;
  assign irqCtlWr  = regWr && regAddr == 6'h14;
  assign rxEndBeat = rxValid && rxReady && rxLast;

  assert_rxend_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    rxEndBeat && !irqCtlWr |=> irq);

  assert_tx_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady && !irqCtlWr |=> txValid && $stable(txData) && $stable(txLast));

  assert_rx_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> !busy);

  assert_txcnt_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    32'(txCount) <= MAX_FRAME);

  assert_rx_pop_R10: assert property (@(posedge clk) disable iff (!rstN)
    regRd && regAddr == 6'h1c && rxCount != '0 && !regWr && !rxEndBeat
    |=> rxCount == $past(rxCount) - 1'b1);

  assert_stall_tx_R6: assert property (@(posedge clk) disable iff (!rstN)
    hostStall |-> txValid);

  assert_rxend_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxEndBeat |=> busy);

endmodule

bind pio_frame_nic nic_checker #(.MAX_FRAME(MAX_FRAME), .PTR_W(PTR_W)) uChk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
  .regWData(regWData), .irq(irq), .hostStall(hostStall), .txData(txData),
  .txValid(txValid), .txReady(txReady), .txLast(txLast), .rxValid(rxValid),
  .rxReady(rxReady), .rxLast(rxLast), .busy(busy), .rxCount(rxCount),
  .txCount(txCount)
);

// File: tb/tb_pio_frame_nic.sv
module tb_pio_frame_nic;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 20;

  localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08, A_RXCNT = 6'h0c;
  localparam logic [5:0] A_TXCNT = 6'h10, A_IRQ = 6'h14, A_INFO = 6'h18;
  localparam logic [5:0] A_RXD = 6'h1c, A_TXD = 6'h20;

  logic clk = 1'b0, rstN = 1'b0;
  logic [5:0] regAddr = '0;
  logic regWr = 1'b0, regRd = 1'b0;
  logic [31:0] regWData = '0, regRData;
  logic hostStall, irq, txValid, txLast, rxReady;
  logic txReady = 1'b1;
  logic [7:0] txData, rxData = '0;
  logic rxValid = 1'b0, rxLast = 1'b0;

  pio_frame_nic #(.MAX_FRAME(MAXF)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWData(regWData), .regRData(regRData), .hostStall(hostStall), .irq(irq),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txLast(txLast),
    .rxData(rxData), .rxValid(rxValid), .rxLast(rxLast), .rxReady(rxReady)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // transmit stream capture
  logic [7:0] capData [256];
  logic       capLast [256];
  int capN = 0;
  always @(posedge clk) begin
    if (txValid && txReady && capN < 256) begin
      capData[capN] = txData;
      capLast[capN] = txLast;
      capN++;
    end
  end

  // ready pattern on the outgoing stream: stalls every third cycle
  int cyc = 0;
  always @(negedge clk) begin
    cyc++;
    txReady = (cyc % 3) != 1;
  end

  function automatic logic [7:0] txByteOf(int len, int i);
    return 8'((len * 7 + i * 3) & 255);
  endfunction
  function automatic logic [7:0] rxByteOf(int len, int i);
    return 8'((len * 11 + i * 5 + 1) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(posedge clk);
    #1 regWr = 1'b0;
  endtask

  task automatic rdChk(logic [5:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRData;
    @(posedge clk);
    #1 regRd = 1'b0;
    check(req, d, exp);
  endtask

  task automatic sendRx(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 1'b1; rxData = rxByteOf(n, i); rxLast = (i == n - 1);
      #1;
      while (!rxReady) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
      #1 rxValid = 1'b0; rxLast = 1'b0;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    #1;
    check("R1 irq", irq, 0);
    check("R1 txValid", txValid, 0);
    check("R1 rxReady", rxReady, 0);
    rdChk(A_BUSY, 1, "R1 busy");
    rdChk(A_RXCNT, 0, "R1 rxcnt");
    rdChk(A_TXCNT, 0, "R1 txcnt");
    rdChk(A_IRQ, 0, "R1 irqctl");

    // R2 map, read-only writes
    rdChk(A_ID0, 32'h5046_4E49, "R2 id0");
    rdChk(A_ID1, 32'h4330_0001, "R2 id1");
    rdChk(A_INFO, 0, "R2 info");
    rdChk(A_TXD, 0, "R2 txdata read");
    rdChk(6'h3c, 0, "R2 unmapped");
    wr(A_BUSY, 0);
    wr(A_RXCNT, 5);
    wr(A_ID0, 32'hFFFF_FFFF);
    rdChk(A_BUSY, 1, "R2 busy write ignored");
    rdChk(A_RXCNT, 0, "R2 rxcnt write ignored");
    rdChk(A_ID0, 32'h5046_4E49, "R2 id write ignored");

    // R3 write of zero: busy follows flags
    wr(A_IRQ, 0);
    rdChk(A_BUSY, 0, "R3 busy after zero write");

    // R5 count limits and R6 zero count
    wr(A_TXCNT, MAXF + 1);
    rdChk(A_TXCNT, 0, "R5 oversize count");
    wr(A_TXCNT, MAXF);
    rdChk(A_TXCNT, MAXF, "R5 max count");
    wr(A_TXCNT, 0);
    wr(A_TXD, 8'h55);
    repeat (3) @(negedge clk);
    check("R6 zero count no send", txValid, 0);
    check("R6 zero count no irq", irq, 0);

    // R6/R7 transmit sweep
    for (int len = 1; len <= MAXF; len++) begin
      wr(A_TXCNT, len);
      rdChk(A_TXCNT, len, "R5 count load");
      base = capN;
      for (int i = 0; i < len; i++) wr(A_TXD, {24'b0, txByteOf(len, i)});
      while (hostStall) @(negedge clk);
      repeat (2) @(negedge clk);
      check("R6 frame length", capN - base, len);
      for (int i = 0; i < len; i++) begin
        check("R7 tx byte", capData[base + i], txByteOf(len, i));
        check("R6 tx last", capLast[base + i], (i == len - 1));
      end
      check("R3 irq on tx done", irq, 1);
      rdChk(A_IRQ, 1, "R6 txdone flag");
      rdChk(A_BUSY, 1, "R6 busy after send");
      rdChk(A_TXCNT, 0, "R6 count cleared");
      wr(A_IRQ, 1);
      #1 check("R3 irq low after clear", irq, 0);
      rdChk(A_BUSY, 0, "R3 busy after clear");
    end

    // R8/R9/R10 receive sweep including oversize frames
    for (int len = 1; len <= MAXF + 3; len++) begin
      int kept;
      kept = (len > MAXF) ? MAXF : len;
      sendRx(len);
      repeat (2) @(negedge clk);
      check("R9 irq on rx done", irq, 1);
      rdChk(A_IRQ, 2, "R9 rxdone flag");
      rdChk(A_BUSY, 1, "R8 busy after rx");
      rdChk(A_RXCNT, kept, "R9 rx count");
      for (int i = 0; i < kept; i++) begin
        rdChk(A_RXD, {24'b0, rxByteOf(len, i)}, "R10 rx byte");
      end
      rdChk(A_RXCNT, 0, "R10 count drained");
      rdChk(A_RXD, 0, "R10 empty read");
      wr(A_IRQ, 2);
      rdChk(A_BUSY, 0, "R3 busy after rx clear");
    end

    // R8 gating while busy
    sendRx(3);
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hAA; rxLast = 1'b0;
    for (int k = 0; k < 4; k++) begin
      #1 check("R8 ready low while busy", rxReady, 0);
      @(negedge clk);
    end
    rxValid = 1'b0;
    wr(A_IRQ, 2);
    sendRx(2);
    repeat (2) @(negedge clk);
    rdChk(A_RXCNT, 2, "R8 accepted after clear");
    rdChk(A_RXD, {24'b0, rxByteOf(2, 0)}, "R8 new frame byte0");
    rdChk(A_RXD, {24'b0, rxByteOf(2, 1)}, "R8 new frame byte1");
    wr(A_IRQ, 2);

    // R8 count boundary
    sendRx(MAXF);
    wr(A_IRQ, 2);
    #1 check("R8 ready low at full count", rxReady, 0);
    rdChk(A_RXD, {24'b0, rxByteOf(MAXF, 0)}, "R10 pop at full");
    #1 check("R8 ready high below full", rxReady, 1);
    sendRx(1);
    repeat (2) @(negedge clk);
    rdChk(A_RXCNT, 1, "R9 short frame after full");
    rdChk(A_RXD, {24'b0, rxByteOf(1, 0)}, "R10 short frame byte");
    wr(A_IRQ, 2);

    // R11 collisions
    wr(A_TXCNT, 1);
    base = capN;
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'h3C; rxLast = 1'b0;
    regAddr = A_IRQ; regWData = 0; regWr = 1'b1;
    #1 check("R11 ready at start", rxReady, 1);
    @(posedge clk);
    #1 begin regWr = 1'b0; rxValid = 1'b0; end
    rdChk(A_BUSY, 1, "R11 start beats zero write");
    @(negedge clk);
    rxValid = 1'b1; rxData = 8'hC3; rxLast = 1'b1;
    regAddr = A_TXD; regWData = 32'h0000_005A; regWr = 1'b1;
    @(posedge clk);
    #1 begin regWr = 1'b0; rxValid = 1'b0; rxLast = 1'b0; end
    while (hostStall) @(negedge clk);
    repeat (2) @(negedge clk);
    rdChk(A_IRQ, 3, "R11 both done flags");
    rdChk(A_BUSY, 1, "R11 busy");
    rdChk(A_RXCNT, 2, "R11 rx count");
    check("R11 tx sent", capN - base, 1);
    check("R11 tx byte", capData[base], 8'h5A);
    rdChk(A_RXD, 8'h3C, "R11 rx byte0");
    rdChk(A_RXD, 8'hC3, "R11 rx byte1");

    // R3 priority
    wr(A_IRQ, 3);
    rdChk(A_IRQ, 2, "R3 bit0 wins over bit1");
    wr(A_IRQ, 32'h8000_0002);
    rdChk(A_IRQ, 0, "R3 bit1 wins over test bit");
    rdChk(A_BUSY, 0, "R3 busy none left");

    // R4 test bit soft reset
    wr(A_TXCNT, 5);
    wr(A_TXD, 1);
    wr(A_TXD, 2);
    wr(A_IRQ, 32'h8000_0000);
    #1 check("R4 irq from test bit", irq, 1);
    rdChk(A_IRQ, 32'h8000_0000, "R4 test bit read");
    rdChk(A_IRQ, 0, "R4 cleared by read");
    #1 check("R4 irq low after read", irq, 0);
    rdChk(A_TXCNT, 0, "R4 soft reset count");
    rdChk(A_BUSY, 1, "R4 busy held");
    wr(A_IRQ, 0);
    rdChk(A_BUSY, 0, "R4 busy released");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule